// File: doc/BRIEF.md
# Protection entry allocator

This block hands out slots in a small table of memory-protection entries. Each slot has one bit in a used mask. A caller asks for either one slot or for a pair of adjacent slots. A pair is what a top-of-range region needs: the lower slot holds the start address and the upper slot holds the end. The allocator looks at the current mask and picks the lowest slot that fits. It returns that slot's index and marks what it gave out as used. If nothing fits, it raises an exhaustion error and leaves the mask as it was.

For a pair, the returned index is the upper slot, so the caller programs slot `n` and slot `n-1`. The number of slots that exist is set by a parameter of at most 16. Slots at or above that count are never handed out. A clear input empties the whole mask in one cycle so a fresh layout can be built.

Top module: `pea_alloc`

## Requirements
- R1: After reset, `gnt` and `full_err` are low and every slot is free, so the first single request is granted index 0.
- R2: A single request (`is_range`=0) is granted the lowest-numbered free slot below `IMPL_SLOTS`.
- R3: A pair request (`is_range`=1) is granted the lowest index `n` (with `n` ≥ 1) such that slots `n` and `n-1` are both free. `gnt_idx` carries `n`, the upper slot.
- R4: A single grant marks slot `n` used. A pair grant marks slots `n` and `n-1` used. Later requests never receive a slot that is already marked.
- R5: When no fitting slot exists, `full_err` is high for one cycle, `gnt` stays low, and the mask is unchanged.
- R6: Slots at index `IMPL_SLOTS` or above are never granted, and neither is a pair whose upper slot is one of them.
- R7: A `clr` high at a clock edge zeroes the whole mask at that edge. A request presented in the same cycle is dropped: it produces neither a grant nor an error.
- R8: Each accepted request produces exactly one result, either `gnt` or `full_err` and never both. That result is high for exactly one cycle, the cycle after the request.
- R9: `gnt_idx` is the plain binary slot number, 0 to 15, valid while `gnt` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties the used mask; takes priority over a request |
| req | input | 1 | Allocation request, one per high cycle |
| is_range | input | 1 | 1 = two adjacent slots, 0 = one slot |
| gnt | output | 1 | One-cycle grant pulse |
| gnt_idx | output | 4 | Granted slot (upper slot of a pair) |
| full_err | output | 1 | One-cycle exhaustion pulse |

## Verification
A request is sampled at one edge. The search is combinational, so its `gnt` or `full_err` result and `gnt_idx` appear after that same edge, one cycle later, and the mask update lands at that same edge. The bench drives each request half a cycle before the edge. It reads the result at the following falling edge, then reads again one cycle later to confirm that the pulse has ended. Because the mask is already updated, the next request sees it. A bench model updates its own mask in the same step, and two instances with different slot counts get the same stimulus. A clear is checked by driving a request together with `clr` and showing that no result follows and the next single request receives index 0.

// File: rtl/pea_pkg.sv
package pea_pkg;

    localparam int MAX_SLOTS = 16;
    localparam int IDX_W     = $clog2(MAX_SLOTS);

    typedef logic [MAX_SLOTS-1:0] slot_vec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_GRANT = 2'd1,
        RES_FULL  = 2'd2
    } result_e;

    // Lowest set bit of a candidate vector; hit=0 when the vector is empty.
    function automatic pick_t lowest_set(slot_vec_t v);
        pick_t r;
        r = '0;
        for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = i[IDX_W-1:0];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pea_search.sv
module pea_search
    import pea_pkg::*;
#(
    parameter int IMPL_SLOTS = 16
) (
    input  slot_vec_t used,
    input  logic      is_range,
    output pick_t     pick
);
    localparam int LIMIT = (IMPL_SLOTS > MAX_SLOTS) ? MAX_SLOTS : IMPL_SLOTS;

    slot_vec_t single_ok;
    slot_vec_t pair_ok;

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        if (g < LIMIT) begin : g_live
            assign single_ok[g] = ~used[g];
            if (g == 0) begin : g_base
                assign pair_ok[g] = 1'b0;
            end else begin : g_upper
                assign pair_ok[g] = ~used[g] & ~used[g-1];
            end
        end else begin : g_absent
            assign single_ok[g] = 1'b0;
            assign pair_ok[g]   = 1'b0;
        end
    end

    always_comb begin
        pick = lowest_set(is_range ? pair_ok : single_ok);
    end
endmodule

// File: rtl/pea_mask.sv
module pea_mask
    import pea_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      set_en,
    input  slot_vec_t set_vec,
    output slot_vec_t used_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
        end else if (set_en) begin
            used_q <= used_q | set_vec;
        end
    end
endmodule

// File: rtl/pea_alloc.sv
module pea_alloc
    import pea_pkg::*;
#(
    parameter int IMPL_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             req,
    input  logic             is_range,
    output logic             gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             full_err
);
    slot_vec_t  used_q;
    slot_vec_t  set_vec;
    pick_t      pick;
    result_e    res_d;
    result_e    res_q;
    logic [IDX_W-1:0] idx_q;
    logic       take;

    assign take = req & ~clr;

    pea_search #(.IMPL_SLOTS(IMPL_SLOTS)) u_search (
        .used     (used_q),
        .is_range (is_range),
        .pick     (pick)
    );

    // Bits to mark: the granted slot, plus the one below it for a pair.
    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_mark
        if (g == MAX_SLOTS - 1) begin : g_top
            assign set_vec[g] = (pick.idx == IDX_W'(g));
        end else begin : g_low
            assign set_vec[g] = (pick.idx == IDX_W'(g)) |
                                (is_range & (pick.idx == IDX_W'(g + 1)));
        end
    end

    pea_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .set_en (take & pick.hit),
        .set_vec(set_vec),
        .used_q (used_q)
    );

    always_comb begin
        if (!take)         res_d = RES_NONE;
        else if (pick.hit) res_d = RES_GRANT;
        else               res_d = RES_FULL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RES_NONE;
            idx_q <= '0;
        end else begin
            res_q <= res_d;
            if (res_d == RES_GRANT) idx_q <= pick.idx;
        end
    end

    assign gnt      = (res_q == RES_GRANT);
    assign full_err = (res_q == RES_FULL);
    assign gnt_idx  = idx_q;
endmodule

// File: rtl/pea_alloc_chk.sv
module pea_alloc_chk
    import pea_pkg::*;
#(
    parameter int IMPL_SLOTS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             req,
    input logic             is_range,
    input logic             gnt,
    input logic [IDX_W-1:0] gnt_idx,
    input logic             full_err,
    input slot_vec_t        used_q
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(gnt && full_err));                                                  // R8
    AST_RESULT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt || full_err) |-> ($past(req) && !$past(clr)));                   // R8
    AST_IDX_IMPLEMENTED: assert property (@(posedge clk) disable iff (rst)
        gnt |-> (int'(gnt_idx) < IMPL_SLOTS));                                 // R6
    AST_PAIR_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (gnt && $past(is_range)) |-> (gnt_idx != '0));                         // R3
    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (rst)
        gnt |-> used_q[gnt_idx]);                                              // R4
    AST_FULL_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
        full_err |-> (used_q == $past(used_q)));                               // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (used_q == '0 && !gnt && !full_err));                   // R7
endmodule

bind pea_alloc pea_alloc_chk #(.IMPL_SLOTS(IMPL_SLOTS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .req     (req),
    .is_range(is_range),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .full_err(full_err),
    .used_q  (used_q)
);

// File: tb/pea_alloc_bench.sv
module pea_alloc_bench;
    localparam int SMALL = 5;

    logic clk = 1'b0;
    logic rst, clr, req, is_range;
    logic       gnt_a, err_a, gnt_b, err_b;
    logic [3:0] idx_a, idx_b;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl_a, mdl_b;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    pea_alloc #(.IMPL_SLOTS(16)) u_pea_alloc (
        .clk(clk), .rst(rst), .clr(clr), .req(req), .is_range(is_range),
        .gnt(gnt_a), .gnt_idx(idx_a), .full_err(err_a)
    );

    pea_alloc #(.IMPL_SLOTS(SMALL)) u_pea_alloc_small (
        .clk(clk), .rst(rst), .clr(clr), .req(req), .is_range(is_range),
        .gnt(gnt_b), .gnt_idx(idx_b), .full_err(err_b)
    );

    function automatic int expect_pick(logic [15:0] m, bit rng, int impl);
        for (int n = 0; n < impl; n++) begin
            if (!rng && !m[n]) return n;
            if (rng && n >= 1 && !m[n] && !m[n-1]) return n;
        end
        return -1;
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic check_one(string tag, logic g, logic e, logic [3:0] ix,
                             int exp, string rq);
        if (exp < 0) begin
            check(e && !g, {rq, " R5 full ", tag}, {g, e}, 1);
        end else begin
            check(g && !e && int'(ix) == exp, {rq, " grant ", tag},
                  g ? int'(ix) : -1, exp);
        end
    endtask

    task automatic do_req(bit rng);
        int ea, eb;
        ea = expect_pick(mdl_a, rng, 16);
        eb = expect_pick(mdl_b, rng, SMALL);
        @(negedge clk);
        req = 1'b1; is_range = rng;
        @(negedge clk);
        req = 1'b0;
        check_one("a", gnt_a, err_a, idx_a, ea, rng ? "R3/R4" : "R2/R4");
        check_one("b", gnt_b, err_b, idx_b, eb, rng ? "R3/R6" : "R2/R6");
        if (ea >= 0) begin
            mdl_a[ea] = 1'b1;
            if (rng) mdl_a[ea-1] = 1'b1;
        end
        if (eb >= 0) begin
            mdl_b[eb] = 1'b1;
            if (rng) mdl_b[eb-1] = 1'b1;
        end
        @(negedge clk);
        check(!gnt_a && !err_a && !gnt_b && !err_b, "R8 pulse width",
              {gnt_a, err_a, gnt_b, err_b}, 0);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; req = 1'b1; is_range = 1'b0;
        @(negedge clk);
        clr = 1'b0; req = 1'b0;
        check(!gnt_a && !err_a && !gnt_b && !err_b, "R7 dropped req",
              {gnt_a, err_a, gnt_b, err_b}, 0);
        mdl_a = '0; mdl_b = '0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; clr = 1'b0; req = 1'b0; is_range = 1'b0;
        mdl_a = '0; mdl_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!gnt_a && !err_a && !gnt_b && !err_b, "R1 reset outputs",
              {gnt_a, err_a, gnt_b, err_b}, 0);
        do_req(1'b0);
        check(idx_a == 4'd0, "R1 R9 first index", int'(idx_a), 0);

        // singles until both are exhausted
        for (int k = 0; k < 17; k++) do_req(1'b0);

        do_clear();
        do_req(1'b0);
        check(idx_a == 4'd0 && idx_b == 4'd0, "R7 index after clear",
              int'(idx_a), 0);

        // pairs: small instance has one orphan slot left, then a single fits it
        do_clear();
        for (int k = 0; k < 9; k++) do_req(1'b1);
        do_req(1'b0);

        // mixed random sequences
        for (int round = 0; round < 150; round++) begin
            do_clear();
            for (int k = 0; k < 14; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                do_req(lfsr[0]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule